// File: doc/BRIEF.md
# Serial Control-Line Restart Sequence Detector

This block sits behind a serial-port emulation endpoint and watches the two modem control lines, request-to-send (RTS) and data-terminal-ready (DTR), that a host sets and clears. Each time the host reports the lines, the block receives a one-cycle strobe with a 2-bit value. The value uses the host software's view of the lines, where 1 means the line is asserted ("true"). A single-state decode would restart the device on every transient. This block instead acts only on particular ordered walks through the line states. It then emits either a one-cycle restart request or a one-cycle request to restart into the firmware-download loader.

Two command sets are available, selected by a mode input. The primary set has a download walk and a plain-restart walk. The plain-restart walk must pass through an idle both-false state before the final step, so a short RTS-only glitch cannot trigger a restart. The alternative set has only a four-step download walk and no way to request a plain restart. A step that breaks a walk abandons it, and that same step is then evaluated as the possible start of a new walk. A report that repeats the current line state is ignored. An optional cycle limit abandons a walk whose next step arrives too late. An enable input mutes every request.

Top module: `line_seq_detect`

## Requirements
- R1: Line values are encoded {RTS, DTR} with bit 1 = RTS and bit 0 = DTR, 1 meaning asserted. With `alt_mode_i` low, the changed reports 2'b01 then 2'b10 raise `download_pulse_o` for one cycle, in the cycle after the edge that samples the final report.
- R2: With `alt_mode_i` low, the changed reports 2'b11, then 2'b00, then 2'b10 raise `restart_pulse_o` for one cycle, with the same timing as in R1.
- R3: With `alt_mode_i` low, a 2'b10 report that does not complete a walk produces no pulse.
- R4: With `alt_mode_i` high, the changed reports 2'b10, 2'b11, 2'b01, 2'b00, in that order, raise `download_pulse_o` for one cycle.
- R5: With `alt_mode_i` high, `restart_pulse_o` never rises, and the primary-set walks produce no pulse.
- R6: A changed report that is not the next expected step abandons the walk. The same report is then taken as a possible first step of a new walk.
- R7: A strobed report equal to the last reported value is ignored. It neither advances nor breaks a walk and produces no pulse. Only reports with `upd_valid_i` high are acted on.
- R8: When `gap_limit_i` is nonzero and a walk is in progress, the next step must be sampled no more than `gap_limit_i` clock edges after the previous step, or the walk is abandoned. A value of 0 disables the limit.
- R9: Every pulse lasts exactly one cycle, and the two pulses are never high together.
- R10: While `req_enable_i` is low, neither pulse is raised and no walk progresses. The last line value is still tracked.
- R11: After reset, both pulses are low, no walk is in progress, and the last line value is taken as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid_i | input | 1 | Strobe marking a line-state report |
| upd_lines_i | input | 2 | Reported {RTS, DTR}, 1 = asserted |
| alt_mode_i | input | 1 | 0 = primary command set, 1 = alternative download-only set |
| req_enable_i | input | 1 | 1 allows requests; 0 mutes them and holds the detector idle |
| gap_limit_i | input | GAP_W | Maximum edges between steps; 0 = no limit |
| restart_pulse_o | output | 1 | One-cycle plain-restart request |
| download_pulse_o | output | 1 | One-cycle restart-into-download request |

## Verification
The bench sends a lone RTS-only report from idle. A detector that decoded single states would restart on it. It breaks a plain-restart walk with a download-start report and with a both-true report. A design that did not re-evaluate the breaking step would then miss the walks that follow. It inserts a repeated both-true report mid-walk, which a design that treats repeats as mismatches would lose. It places the next step exactly at the gap limit and one edge past it, which exposes an off-by-one in the timeout. It also checks that the alternative set ignores primary-set walks and that a muted detector does not resume a walk once re-enabled.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;

    typedef struct packed {
        logic rts;
        logic dtr;
    } lines_t;

    localparam lines_t LN_NONE = '{rts: 1'b0, dtr: 1'b0};
    localparam lines_t LN_DTR  = '{rts: 1'b0, dtr: 1'b1};
    localparam lines_t LN_RTS  = '{rts: 1'b1, dtr: 1'b0};
    localparam lines_t LN_BOTH = '{rts: 1'b1, dtr: 1'b1};

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_P_DL1,
        PH_P_RS1,
        PH_P_RS2,
        PH_A_1,
        PH_A_2,
        PH_A_3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   restart;
        logic   download;
    } step_t;

    function automatic step_t first_step(input lines_t ln, input logic alt);
        step_t r;
        r = '{phase: PH_IDLE, restart: 1'b0, download: 1'b0};
        if (alt) begin
            if (ln == LN_RTS) r.phase = PH_A_1;
        end else begin
            if (ln == LN_DTR)       r.phase = PH_P_DL1;
            else if (ln == LN_BOTH) r.phase = PH_P_RS1;
        end
        return r;
    endfunction

    function automatic step_t advance(input phase_e ph, input lines_t ln, input logic alt);
        step_t r;
        r = first_step(ln, alt);
        if (!alt) begin
            case (ph)
                PH_P_DL1: if (ln == LN_RTS)
                    r = '{phase: PH_IDLE, restart: 1'b0, download: 1'b1};
                PH_P_RS1: if (ln == LN_NONE)
                    r = '{phase: PH_P_RS2, restart: 1'b0, download: 1'b0};
                PH_P_RS2: if (ln == LN_RTS)
                    r = '{phase: PH_IDLE, restart: 1'b1, download: 1'b0};
                default: ;
            endcase
        end else begin
            case (ph)
                PH_A_1: if (ln == LN_BOTH)
                    r = '{phase: PH_A_2, restart: 1'b0, download: 1'b0};
                PH_A_2: if (ln == LN_DTR)
                    r = '{phase: PH_A_3, restart: 1'b0, download: 1'b0};
                PH_A_3: if (ln == LN_NONE)
                    r = '{phase: PH_IDLE, restart: 1'b0, download: 1'b1};
                default: ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/line_change_filter.sv
module line_change_filter
    import line_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_i,
    input  lines_t lines_i,
    output logic   change_o
);
    lines_t last_q;

    always_ff @(posedge clk) begin
        if (rst)          last_q <= LN_NONE;
        else if (valid_i) last_q <= lines_i;
    end

    assign change_o = valid_i && (lines_i != last_q);
endmodule

// File: rtl/step_gap_timer.sv
module step_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             step_i,
    input  logic [GAP_W-1:0] limit_i,
    output logic             expired_o
);
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] lim_m1;

    assign lim_m1    = limit_i - 1'b1;
    assign expired_o = (limit_i != '0) && busy_i && !step_i && (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !busy_i || step_i) cnt_q <= '0;
        else if (cnt_q != '1)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/seq_walker.sv
module seq_walker
    import line_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   change_i,
    input  lines_t lines_i,
    input  logic   alt_i,
    input  logic   enable_i,
    input  logic   expired_i,
    output logic   busy_o,
    output logic   restart_o,
    output logic   download_o
);
    phase_e phase_q;
    step_t  nxt;

    always_comb begin
        nxt = '{phase: phase_q, restart: 1'b0, download: 1'b0};
        if (!enable_i)      nxt.phase = PH_IDLE;
        else if (change_i)  nxt = advance(phase_q, lines_i, alt_i);
        else if (expired_i) nxt.phase = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            restart_o  <= 1'b0;
            download_o <= 1'b0;
        end else begin
            phase_q    <= nxt.phase;
            restart_o  <= nxt.restart;
            download_o <= nxt.download;
        end
    end

    assign busy_o = (phase_q != PH_IDLE);
endmodule

// File: rtl/line_seq_detect.sv
module line_seq_detect
    import line_seq_pkg::*;
#(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid_i,
    input  logic [1:0]       upd_lines_i,
    input  logic             alt_mode_i,
    input  logic             req_enable_i,
    input  logic [GAP_W-1:0] gap_limit_i,
    output logic             restart_pulse_o,
    output logic             download_pulse_o
);
    lines_t ln;
    logic   change, busy, expired;

    assign ln = lines_t'(upd_lines_i);

    line_change_filter u_filter (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (upd_valid_i),
        .lines_i  (ln),
        .change_o (change)
    );

    step_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .busy_i    (busy),
        .step_i    (change),
        .limit_i   (gap_limit_i),
        .expired_o (expired)
    );

    seq_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .change_i   (change),
        .lines_i    (ln),
        .alt_i      (alt_mode_i),
        .enable_i   (req_enable_i),
        .expired_i  (expired),
        .busy_o     (busy),
        .restart_o  (restart_pulse_o),
        .download_o (download_pulse_o)
    );
endmodule

// File: rtl/line_seq_detect_chk.sv
module line_seq_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       upd_valid_i,
    input logic [1:0] upd_lines_i,
    input logic       alt_mode_i,
    input logic       req_enable_i,
    input logic       restart_pulse_o,
    input logic       download_pulse_o
);
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)              seen_q <= 2'b00;
        else if (upd_valid_i) seen_q <= upd_lines_i;
    end

    a_r9_restart_one_cycle: assert property (@(posedge clk) disable iff (rst)
        restart_pulse_o |=> !restart_pulse_o);
    a_r9_download_one_cycle: assert property (@(posedge clk) disable iff (rst)
        download_pulse_o |=> !download_pulse_o);
    a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
        !(restart_pulse_o && download_pulse_o));
    a_r10_muted: assert property (@(posedge clk) disable iff (rst)
        !req_enable_i |=> (!restart_pulse_o && !download_pulse_o));
    a_r5_alt_no_restart: assert property (@(posedge clk) disable iff (rst)
        alt_mode_i |=> !restart_pulse_o);
    a_r7_no_strobe_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !upd_valid_i |=> (!restart_pulse_o && !download_pulse_o));
    a_r7_repeat_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_lines_i == seen_q) |=> (!restart_pulse_o && !download_pulse_o));
endmodule

bind line_seq_detect line_seq_detect_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .upd_valid_i      (upd_valid_i),
    .upd_lines_i      (upd_lines_i),
    .alt_mode_i       (alt_mode_i),
    .req_enable_i     (req_enable_i),
    .restart_pulse_o  (restart_pulse_o),
    .download_pulse_o (download_pulse_o)
);

// File: tb/line_seq_detect_tb_top.sv
`timescale 1ns/1ps
module line_seq_detect_tb_top;
    localparam int GAP_W = 16;
    localparam int NV    = 28;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_valid_i = 1'b0;
    logic [1:0]       upd_lines_i = 2'b00;
    logic             alt_mode_i = 1'b0;
    logic             req_enable_i = 1'b1;
    logic [GAP_W-1:0] gap_limit_i = '0;
    logic             restart_pulse_o, download_pulse_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    line_seq_detect #(.GAP_W(GAP_W)) dut_i (.*);

    // entry: {req id, alt, lines{RTS,DTR}, expected restart, expected download}
    localparam logic [8:0] VEC [NV] = '{
        {4'd1,  1'b0, 2'b01, 1'b0, 1'b0},  // R1 first step
        {4'd1,  1'b0, 2'b10, 1'b0, 1'b1},  // R1 download
        {4'd2,  1'b0, 2'b11, 1'b0, 1'b0},  // R2
        {4'd2,  1'b0, 2'b00, 1'b0, 1'b0},  // R2
        {4'd2,  1'b0, 2'b10, 1'b1, 1'b0},  // R2 restart
        {4'd3,  1'b0, 2'b00, 1'b0, 1'b0},  // R3
        {4'd3,  1'b0, 2'b10, 1'b0, 1'b0},  // R3 stray RTS, no restart
        {4'd6,  1'b0, 2'b11, 1'b0, 1'b0},  // R6
        {4'd6,  1'b0, 2'b01, 1'b0, 1'b0},  // R6 breaks, restarts walk
        {4'd6,  1'b0, 2'b10, 1'b0, 1'b1},  // R6 re-evaluated download
        {4'd7,  1'b0, 2'b11, 1'b0, 1'b0},  // R7
        {4'd7,  1'b0, 2'b11, 1'b0, 1'b0},  // R7 repeat ignored
        {4'd7,  1'b0, 2'b00, 1'b0, 1'b0},  // R7 walk continues
        {4'd6,  1'b0, 2'b11, 1'b0, 1'b0},  // R6 break, new first step
        {4'd6,  1'b0, 2'b00, 1'b0, 1'b0},  // R6
        {4'd6,  1'b0, 2'b10, 1'b1, 1'b0},  // R6 restart
        {4'd4,  1'b1, 2'b11, 1'b0, 1'b0},  // R4
        {4'd4,  1'b1, 2'b10, 1'b0, 1'b0},  // R4 step 1
        {4'd4,  1'b1, 2'b11, 1'b0, 1'b0},  // R4 step 2
        {4'd4,  1'b1, 2'b01, 1'b0, 1'b0},  // R4 step 3
        {4'd4,  1'b1, 2'b00, 1'b0, 1'b1},  // R4 download
        {4'd5,  1'b1, 2'b11, 1'b0, 1'b0},  // R5
        {4'd5,  1'b1, 2'b00, 1'b0, 1'b0},  // R5
        {4'd5,  1'b1, 2'b10, 1'b0, 1'b0},  // R5 no restart walk
        {4'd5,  1'b1, 2'b01, 1'b0, 1'b0},  // R5
        {4'd5,  1'b1, 2'b00, 1'b0, 1'b0},  // R5
        {4'd5,  1'b1, 2'b01, 1'b0, 1'b0},  // R5 primary download ignored
        {4'd5,  1'b1, 2'b10, 1'b0, 1'b0}   // R5
    };

    task automatic chk(input int req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // called at a negedge; report sampled on the next posedge, returns at the following negedge
    task automatic send(input logic [1:0] s);
        upd_valid_i = 1'b1;
        upd_lines_i = s;
        @(negedge clk);
        upd_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R11 reset state
        chk(11, "restart after reset", restart_pulse_o, 1'b0);
        chk(11, "download after reset", download_pulse_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            alt_mode_i = VEC[i][4];
            send(VEC[i][3:2]);
            chk(int'(VEC[i][8:5]), $sformatf("vec %0d restart", i), restart_pulse_o, VEC[i][1]);
            chk(int'(VEC[i][8:5]), $sformatf("vec %0d download", i), download_pulse_o, VEC[i][0]);
        end

        // R10 muted detector
        alt_mode_i = 1'b0;
        req_enable_i = 1'b0;
        send(2'b01);
        send(2'b10);
        chk(10, "muted download", download_pulse_o, 1'b0);
        req_enable_i = 1'b1;
        send(2'b11);
        send(2'b10);
        chk(10, "no walk kept from muted time", download_pulse_o, 1'b0);
        send(2'b00);
        send(2'b01);
        send(2'b10);
        chk(10, "download after re-enable", download_pulse_o, 1'b1);
        idle(1);
        chk(9, "download pulse one cycle", download_pulse_o, 1'b0);

        // R8 gap limit boundary
        gap_limit_i = 16'd4;
        send(2'b01);
        idle(3);
        send(2'b10);
        chk(8, "step at limit accepted", download_pulse_o, 1'b1);
        send(2'b01);
        idle(4);
        send(2'b10);
        chk(8, "step past limit rejected", download_pulse_o, 1'b0);
        send(2'b11);
        idle(2);
        send(2'b00);
        idle(3);
        send(2'b10);
        chk(8, "restart steps within limit", restart_pulse_o, 1'b1);
        idle(1);
        chk(9, "restart pulse one cycle", restart_pulse_o, 1'b0);
        gap_limit_i = '0;
        send(2'b01);
        idle(40);
        send(2'b10);
        chk(8, "limit 0 disables timeout", download_pulse_o, 1'b1);

        // R11 reset mid-walk abandons it and clears line memory
        send(2'b01);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        send(2'b10);
        chk(11, "walk cleared by reset", download_pulse_o, 1'b0);
        send(2'b00);
        chk(11, "line memory reset", restart_pulse_o, 1'b0);

        summary();
    end
endmodule